// File: doc/BRIEF.md
# Guarded Control and Status Register

This block is an 8-bit control and status register that sits behind a byte-write port. Each write returns a one-cycle acknowledge or refusal. The register holds five things:

- a write-enable latch;
- a register-write-enable latch;
- a lock bit that forbids wiper-position writes to the digital potentiometer path;
- two latched status flags that follow two external monitor inputs.

Every incoming write, whether to this register or to the potentiometer path, is judged by the block. It either accepts the write and acknowledges it, or aborts it.

Writes go through a two-step arming sequence. The write-enable latch must be set first. The register-write-enable latch can then be set on top of it. While armed, one full write may update the lock bit and the flags, and the register-write-enable latch then disarms itself. Potentiometer writes are allowed only while writes are enabled and the lock is clear. Writes marked nonvolatile are also refused while the write-protect input is high. A status flag can be set only while its monitor input is high, and it drops as soon as that input is seen low.

Top module: `gcsr_top`

## Requirements
- R1: After reset the register reads 0x00, `lock_o` is 0, and `ack`, `nack` and `dcp_wr_ok` are 0.
- R2: While the write-enable latch (bit 1) is 0, every potentiometer write and every register write other than 0x02 is refused with `nack`, and the register is unchanged.
- R3: While the register-write-enable latch is 0, a register write of 0x02 sets bit 1 and a write of 0x00 (with bit 1 already set) clears it. Both are acknowledged.
- R4: The register-write-enable latch (bit 2) is set only by writing 0x06 while bit 1 is already 1. Any other attempt to set bit 2 is refused, and bit 2 is never 1 while bit 1 is 0.
- R5: While bit 2 is 1, a register write is acknowledged. In that one cycle it loads bit 1, the lock bit (bit 3), flag A (bit 7) and flag B (bit 6) from the data, and it clears bit 2.
- R6: While bit 2 is 0, a register write with any data bit set outside bits 1 and 2 is refused and changes nothing.
- R7: Bits 0, 4 and 5 always read 0, whatever is written.
- R8: A flag written with 1 becomes 1 only if its monitor input is high in the cycle of the write. Flag A follows `mon_hi_in[0]` and flag B follows `mon_hi_in[1]`.
- R9: A flag reads 0 in the cycle after its monitor input is sampled low. This holds even when a write tries to set that flag in the same cycle.
- R10: A potentiometer write is acknowledged, with `dcp_wr_ok` pulsing, only when bit 1 is 1, the lock bit is 0, and it is not the case that both `wr_nv` and `wp_in` are high. Otherwise it gets `nack`.
- R11: `ack` and `nack` arrive in the cycle after the strobe, last exactly one cycle, never appear together, and never appear without a strobe.
- R12: `lock_o` always equals bit 3 of `csr_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_to_dcp | input | 1 | Write target: 1 = potentiometer path, 0 = this register |
| wr_nv | input | 1 | Potentiometer write is nonvolatile |
| wr_data | input | 8 | Register write data |
| wp_in | input | 1 | Write-protect input |
| mon_hi_in | input | 2 | Monitor reset-output levels ([0] for flag A, [1] for flag B) |
| csr_q | output | 8 | Register read value |
| ack | output | 1 | Write accepted (one-cycle pulse) |
| nack | output | 1 | Write aborted (one-cycle pulse) |
| dcp_wr_ok | output | 1 | Potentiometer write permitted (one-cycle pulse) |
| lock_o | output | 1 | Potentiometer write lock |

## Verification
Two actions can hit the same flag in one cycle: an armed register write that sets the flag, and the monitor input being low. The bench provokes this by issuing a write of 0xC2 while one monitor input is held low. It expects the flag on the low input to read 0 and the flag on the high input to read 1. A separate case lowers a monitor input with no strobe at all, and the bench checks that the flag drops on the next cycle with no response pulse.

// File: rtl/gcsr_pkg.sv
package gcsr_pkg;
  localparam int CSR_W   = 8;
  localparam int NFLAG   = 2;
  localparam int WEN_B   = 1;
  localparam int ARM_B   = 2;
  localparam int LOCK_B  = 3;

  // flag i sits at bit (CSR_W-1-i)
  function automatic int flag_pos(input int i);
    return CSR_W - 1 - i;
  endfunction

  typedef struct packed {
    logic wen;
    logic arm;
    logic lock;
  } ctl_t;
endpackage

// File: rtl/gcsr_reg_decode.sv
module gcsr_reg_decode
  import gcsr_pkg::*;
#(
  parameter int DATA_W = CSR_W,
  parameter int NUM_FLAGS = NFLAG
) (
  input  ctl_t                 cur,
  input  logic [DATA_W-1:0]    data,
  output logic                 accept,
  output ctl_t                 nxt,
  output logic [NUM_FLAGS-1:0] flag_val
);
  localparam logic [DATA_W-1:0] CTL_MASK = DATA_W'((1 << WEN_B) | (1 << ARM_B));

  always_comb begin
    nxt = cur;
    accept = 1'b0;
    if (cur.arm) begin
      accept   = 1'b1;
      nxt.wen  = data[WEN_B];
      nxt.arm  = 1'b0;
      nxt.lock = data[LOCK_B];
    end else begin
      accept = ((data & ~CTL_MASK) == '0)
             && !(data[ARM_B] && !(cur.wen && data[WEN_B]))
             && (cur.wen || data[WEN_B]);
      nxt.wen = data[WEN_B];
      nxt.arm = data[ARM_B];
    end
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_fv
    assign flag_val[i] = data[flag_pos(i)];
  end
endmodule

// File: rtl/gcsr_dcp_gate.sv
module gcsr_dcp_gate (
  input  logic wen,
  input  logic lock,
  input  logic nv,
  input  logic wp,
  output logic allow
);
  always_comb begin
    allow = wen && !lock && !(nv && wp);
  end
endmodule

// File: rtl/gcsr_flag.sv
module gcsr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_val,
  input  logic mon_hi,
  output logic q
);
  logic q_d;

  always_comb begin
    q_d = q;
    if (!mon_hi)    q_d = 1'b0;
    else if (wr_en) q_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end
endmodule

// File: rtl/gcsr_top.sv
module gcsr_top
  import gcsr_pkg::*;
#(
  parameter int DATA_W = CSR_W,
  parameter int NUM_FLAGS = NFLAG
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_stb,
  input  logic                 wr_to_dcp,
  input  logic                 wr_nv,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 wp_in,
  input  logic [NUM_FLAGS-1:0] mon_hi_in,
  output logic [DATA_W-1:0]    csr_q,
  output logic                 ack,
  output logic                 nack,
  output logic                 dcp_wr_ok,
  output logic                 lock_o
);
  ctl_t                 ctl_q, ctl_d, dec_nxt;
  logic                 dec_accept, dcp_allow;
  logic [NUM_FLAGS-1:0] flag_q, flag_val;
  logic                 reg_wr, dcp_wr, commit;
  logic                 ack_d, nack_d, dok_d;

  gcsr_reg_decode #(.DATA_W(DATA_W), .NUM_FLAGS(NUM_FLAGS)) u_dec (
    .cur(ctl_q), .data(wr_data), .accept(dec_accept),
    .nxt(dec_nxt), .flag_val(flag_val)
  );

  gcsr_dcp_gate u_gate (
    .wen(ctl_q.wen), .lock(ctl_q.lock), .nv(wr_nv), .wp(wp_in), .allow(dcp_allow)
  );

  always_comb begin
    reg_wr = wr_stb && !wr_to_dcp;
    dcp_wr = wr_stb && wr_to_dcp;
    commit = reg_wr && dec_accept;
    ctl_d  = commit ? dec_nxt : ctl_q;
    dok_d  = dcp_wr && dcp_allow;
    ack_d  = commit || dok_d;
    nack_d = wr_stb && !ack_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      ack       <= 1'b0;
      nack      <= 1'b0;
      dcp_wr_ok <= 1'b0;
    end else begin
      ctl_q     <= ctl_d;
      ack       <= ack_d;
      nack      <= nack_d;
      dcp_wr_ok <= dok_d;
    end
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    gcsr_flag u_flag (
      .clk(clk), .rst_n(rst_n),
      .wr_en(commit && ctl_q.arm), .wr_val(flag_val[i]),
      .mon_hi(mon_hi_in[i]), .q(flag_q[i])
    );
  end

  always_comb begin
    csr_q = '0;
    csr_q[WEN_B]  = ctl_q.wen;
    csr_q[ARM_B]  = ctl_q.arm;
    csr_q[LOCK_B] = ctl_q.lock;
    for (int i = 0; i < NUM_FLAGS; i++) csr_q[flag_pos(i)] = flag_q[i];
    lock_o = ctl_q.lock;
  end
endmodule

// File: rtl/gcsr_chk.sv
module gcsr_chk
  import gcsr_pkg::*;
#(
  parameter int DATA_W = CSR_W,
  parameter int NUM_FLAGS = NFLAG
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_stb,
  input logic                 wr_to_dcp,
  input logic                 wr_nv,
  input logic                 wp_in,
  input logic [NUM_FLAGS-1:0] mon_hi_in,
  input logic [DATA_W-1:0]    csr_q,
  input logic                 ack,
  input logic                 nack,
  input logic                 dcp_wr_ok,
  input logic                 lock_o
);
  assert_resp_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && nack));
  assert_resp_needs_stb_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack || nack) |-> $past(wr_stb));
  assert_stb_gets_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (ack || nack));
  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    csr_q[0] == 1'b0 && csr_q[5:4] == 2'b00);
  assert_arm_needs_wen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    csr_q[ARM_B] |-> csr_q[WEN_B]);
  assert_lock_moves_on_armed_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lock_o) |-> $past(wr_stb && !wr_to_dcp && csr_q[ARM_B]));
  assert_dcp_ok_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dcp_wr_ok |-> (ack && $past(csr_q[WEN_B] && !lock_o && !(wr_nv && wp_in))));

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_fchk
    assert_flag_set_needs_mon_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(csr_q[flag_pos(i)]) |-> $past(mon_hi_in[i]));
    assert_flag_drops_on_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !mon_hi_in[i] |=> !csr_q[flag_pos(i)]);
  end
endmodule

bind gcsr_top gcsr_chk #(.DATA_W(DATA_W), .NUM_FLAGS(NUM_FLAGS)) u_gcsr_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_to_dcp(wr_to_dcp),
  .wr_nv(wr_nv), .wp_in(wp_in), .mon_hi_in(mon_hi_in), .csr_q(csr_q),
  .ack(ack), .nack(nack), .dcp_wr_ok(dcp_wr_ok), .lock_o(lock_o)
);

// File: tb/test_gcsr_top.sv
`timescale 1ns/1ps
module test_gcsr_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_stb, wr_to_dcp, wr_nv, wp_in;
  logic [7:0] wr_data;
  logic [1:0] mon_hi_in;
  logic [7:0] csr_q;
  logic       ack, nack, dcp_wr_ok, lock_o;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gcsr_top i_gcsr_top (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_to_dcp(wr_to_dcp),
    .wr_nv(wr_nv), .wr_data(wr_data), .wp_in(wp_in), .mon_hi_in(mon_hi_in),
    .csr_q(csr_q), .ack(ack), .nack(nack), .dcp_wr_ok(dcp_wr_ok), .lock_o(lock_o)
  );

  // {req, dcp, nv, wp, mon[1:0], data, exp_ack, exp_dok, exp_q}
  localparam logic [26:0] VEC [19] = '{
    {4'd2,  1'b0,1'b0,1'b0,2'b11,8'h00,1'b0,1'b0,8'h00}, // R2 reg write while disabled
    {4'd2,  1'b1,1'b0,1'b0,2'b11,8'h00,1'b0,1'b0,8'h00}, // R2 dcp write while disabled
    {4'd4,  1'b0,1'b0,1'b0,2'b11,8'h06,1'b0,1'b0,8'h00}, // R4 arm without enable
    {4'd3,  1'b0,1'b0,1'b0,2'b11,8'h02,1'b1,1'b0,8'h02}, // R3 enable
    {4'd6,  1'b0,1'b0,1'b0,2'b11,8'h08,1'b0,1'b0,8'h02}, // R6 lock write unarmed
    {4'd10, 1'b1,1'b0,1'b0,2'b11,8'h00,1'b1,1'b1,8'h02}, // R10 dcp allowed
    {4'd10, 1'b1,1'b1,1'b1,2'b11,8'h00,1'b0,1'b0,8'h02}, // R10 nv under protect
    {4'd10, 1'b1,1'b0,1'b1,2'b11,8'h00,1'b1,1'b1,8'h02}, // R10 volatile under protect
    {4'd4,  1'b0,1'b0,1'b0,2'b11,8'h06,1'b1,1'b0,8'h06}, // R4 arm
    {4'd5,  1'b0,1'b0,1'b0,2'b11,8'hFB,1'b1,1'b0,8'hCA}, // R5 R7 armed full write
    {4'd10, 1'b1,1'b0,1'b0,2'b11,8'h00,1'b0,1'b0,8'hCA}, // R10 locked
    {4'd3,  1'b0,1'b0,1'b0,2'b11,8'h00,1'b1,1'b0,8'hC8}, // R3 disable
    {4'd2,  1'b1,1'b0,1'b0,2'b11,8'h00,1'b0,1'b0,8'hC8}, // R2 dcp while disabled
    {4'd3,  1'b0,1'b0,1'b0,2'b11,8'h02,1'b1,1'b0,8'hCA}, // R3 re-enable
    {4'd4,  1'b0,1'b0,1'b0,2'b11,8'h06,1'b1,1'b0,8'hCE}, // R4 arm
    {4'd5,  1'b0,1'b0,1'b0,2'b11,8'h02,1'b1,1'b0,8'h02}, // R5 clear lock and flags
    {4'd4,  1'b0,1'b0,1'b0,2'b11,8'h06,1'b1,1'b0,8'h06}, // R4 arm
    {4'd8,  1'b0,1'b0,1'b0,2'b01,8'hC2,1'b1,1'b0,8'h82}, // R8 flag B blocked
    {4'd10, 1'b1,1'b1,1'b0,2'b11,8'h00,1'b1,1'b1,8'h82}  // R10 nv unprotected
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic dcp, input logic nv, input logic wp,
                    input logic [1:0] mon, input logic [7:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_to_dcp = dcp; wr_nv = nv; wp_in = wp;
    mon_hi_in = mon; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_stb = 1'b0; wr_to_dcp = 1'b0; wr_nv = 1'b0;
    wp_in = 1'b0; wr_data = 8'h00; mon_hi_in = 2'b11;
    repeat (3) @(negedge clk);
    chk("R1 reset value", {23'd0, csr_q, lock_o}, 32'd0);
    chk("R1 reset pulses", {ack, nack, dcp_wr_ok}, 0);
    rst_n = 1'b1;

    for (int k = 0; k < 19; k++) begin
      automatic logic [26:0] v = VEC[k];
      automatic string t = $sformatf("R%0d vec %0d", v[26:23], k);
      wr(v[22], v[21], v[20], v[19:18], v[17:10]);
      chk({t, " ack"}, ack, v[9]);
      chk({t, " nack R11"}, nack, !v[9]);
      chk({t, " dcp_ok"}, dcp_wr_ok, v[8]);
      chk({t, " csr"}, csr_q, v[7:0]);
      chk({t, " lock R12"}, lock_o, v[3]);
      @(negedge clk);
      chk({t, " pulse width R11"}, {ack, nack, dcp_wr_ok}, 0);
    end

    // R9: flag A set attempt while its monitor is low, flag B set in the same write
    wr(1'b0, 1'b0, 1'b0, 2'b11, 8'h06);
    chk("R4 arm again", csr_q, 8'h86);
    wr(1'b0, 1'b0, 1'b0, 2'b10, 8'hC2);
    chk("R9 same-cycle low beats set", csr_q, 8'h42);
    chk("R9 same-cycle ack", ack, 1'b1);
    wr(1'b0, 1'b0, 1'b0, 2'b11, 8'h06);
    wr(1'b0, 1'b0, 1'b0, 2'b11, 8'hC2);
    chk("R8 both flags set", csr_q, 8'hC2);
    // R9: monitor B drops with no strobe
    mon_hi_in = 2'b01;
    @(negedge clk);
    chk("R9 flag B drops", csr_q, 8'h82);
    chk("R11 no pulse without strobe", {ack, nack}, 0);
    mon_hi_in = 2'b11;

    // R6: arm-bit write without enable bit, already enabled
    wr(1'b0, 1'b0, 1'b0, 2'b11, 8'h04);
    chk("R6 R4 arm without enable bit", {nack, csr_q}, {1'b1, 8'h82});

    // R1: asynchronous reset mid-run
    wr(1'b0, 1'b0, 1'b0, 2'b11, 8'h06);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset clears", {csr_q, lock_o, ack, nack, dcp_wr_ok}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    wr(1'b1, 1'b0, 1'b0, 2'b11, 8'h00);
    chk("R2 dcp refused after reset", {ack, nack}, 2'b01);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule